// File: doc/BRIEF.md
# Variable memory-type range resolver

This block keeps a small, parameterised bank of programmable range-descriptor pairs. Each pair has a base word and a mask word. For a physical address it gives back the memory attribute that applies to that address. Software loads the pairs and a fallback attribute through a single write port. The lookup side is purely combinational: the address goes in, and in the same cycle the block returns a hit flag, a resolved attribute code and a one-bit-per-pair vector that shows which descriptors claimed the address.

A descriptor claims an address when the address and the stored base agree on every bit the mask selects. Only page-number bits take part in the compare, so the granularity is 4 KiB. A mask may select bits that are not contiguous, so one descriptor can cover a scattered set of pages. When several descriptors claim the same address, fixed rules merge their attributes. Uncacheable beats everything, write-through beats write-back, and any other disagreement falls back to uncacheable. When nothing claims the address, the programmable fallback attribute is returned.

No state machine is needed. The only sequential elements are the descriptor registers and the fallback register, all written by the port on a clock edge.

Top module: `mtr_resolver`

## Requirements
- R1: After reset every descriptor is invalid and the fallback attribute is 0 (uncacheable). A lookup then gives `lk_hit`=0, `lk_type`=0 and `lk_hit_vec`=0.
- R2: Descriptor i claims address A when its valid flag is set and (A[PA_W-1:12] AND mask) equals (base[PA_W-1:12] AND mask). Bit i of `lk_hit_vec` is then 1, and `lk_hit` is 1 whenever any bit of `lk_hit_vec` is 1.
- R3: A descriptor whose valid flag (mask word bit 11) is clear never claims any address.
- R4: Address bits 11:0 play no part in the match. Base word bits 11:3 and mask word bits 10:0 have no effect.
- R5: Write port encoding for `wr_target`: 0 selects the base word of descriptor `wr_index`, 1 selects its mask word, and 2 selects the fallback attribute (taken from `wr_data[2:0]`; `wr_index` is ignored). A write takes effect at the clock edge on which `wr_en` is sampled high. Lookups are combinational and reflect the new state in the following cycle.
- R6: The attribute code is held in base word bits 2:0. The codes are 0 uncacheable, 1 write-combining, 4 write-through, 5 write-protect and 6 write-back. When only one descriptor claims an address and its code is one of these, `lk_type` equals that code.
- R7: If any claiming descriptor has code 0, the result is 0 with `lk_hit`=1. This lets a small uncacheable descriptor punch a hole in a larger one.
- R8: If the claiming descriptors carry only codes 4 and 6 (both present), the result is 4.
- R9: Several claiming descriptors that all carry the same code give that code. Any other mix of legal codes gives 0.
- R10: A claiming descriptor with code 2, 3 or 7 is treated as uncacheable, and the result is 0.
- R11: When no descriptor claims the address, `lk_hit`=0 and `lk_type` equals the fallback attribute.
- R12: With PA_W=36, base word 0x6 and mask word 0xF_FC00_0800 cover 0x0 through 0x3FF_FFFF as write-back, and address 0x400_0000 is not covered.
- R13: A mask with scattered set bits claims every address that matches the base on just those bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_target | input | 2 | 0 base word, 1 mask word, 2 fallback attribute |
| wr_index | input | IDX_W | Descriptor selected by the write |
| wr_data | input | PA_W | Word to write |
| lk_addr | input | PA_W | Physical address to resolve |
| lk_hit | output | 1 | At least one descriptor claims the address |
| lk_type | output | 3 | Resolved attribute code |
| lk_hit_vec | output | N_RANGES | One bit per claiming descriptor |

## Verification
The three lookup outputs depend only on the current address and register contents, so they are due in the same cycle the address is applied. A register write becomes visible from the first rising edge that samples `wr_en` high. The driver changes the address or write controls just after a rising edge and pushes the expected result into a queue. The monitor pops and compares just after the next falling edge, so every check falls half a cycle after a stimulus, once all writes of earlier edges have landed.

// File: rtl/mtr_pkg.sv
package mtr_pkg;

    localparam int PAGE_LSB  = 12;
    localparam int VALID_BIT = 11;

    typedef logic [2:0] mtype_t;

    localparam mtype_t MT_UC = 3'd0;
    localparam mtype_t MT_WC = 3'd1;
    localparam mtype_t MT_WT = 3'd4;
    localparam mtype_t MT_WP = 3'd5;
    localparam mtype_t MT_WB = 3'd6;

    typedef enum logic [1:0] {
        TGT_BASE = 2'd0,
        TGT_MASK = 2'd1,
        TGT_DFLT = 2'd2
    } wr_target_e;

    function automatic logic is_reserved(input mtype_t t);
        return (t == 3'd2) || (t == 3'd3) || (t == 3'd7);
    endfunction

endpackage

// File: rtl/mtr_range_entry.sv
module mtr_range_entry
    import mtr_pkg::*;
#(
    parameter int PA_W  = 36,
    parameter int IDX   = 0,
    parameter int IDX_W = 2,
    localparam int PG_W = PA_W - PAGE_LSB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_target,
    input  logic [IDX_W-1:0] wr_index,
    input  logic [PG_W-1:0]  wr_page,
    input  logic             wr_flag,
    input  mtype_t           wr_kind,
    input  logic [PG_W-1:0]  lk_page,
    output logic             match,
    output mtype_t           mtype
);

    logic [PG_W-1:0] base_q;
    logic [PG_W-1:0] mask_q;
    logic            valid_q;
    mtype_t          type_q;
    logic            sel;

    assign sel = wr_en && (wr_index == IDX_W'(IDX));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            mask_q  <= '0;
            valid_q <= 1'b0;
            type_q  <= MT_UC;
        end else if (sel) begin
            if (wr_target == TGT_BASE) begin
                base_q <= wr_page;
                type_q <= wr_kind;
            end else if (wr_target == TGT_MASK) begin
                mask_q  <= wr_page;
                valid_q <= wr_flag;
            end
        end
    end

    always_comb begin
        match = valid_q && (((lk_page ^ base_q) & mask_q) == '0);
        mtype = type_q;
    end

    // R3: clearing the valid flag removes the descriptor from every lookup
    a_r3_cleared_valid_blocks_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr_target == TGT_MASK && !wr_flag) |=> !match);

endmodule

// File: rtl/mtr_type_merge.sv
module mtr_type_merge
    import mtr_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [N-1:0]      hit_vec,
    input  logic [N-1:0][2:0] types,
    input  mtype_t            dflt,
    output logic              hit,
    output mtype_t            rtype
);

    logic [7:0] seen;
    mtype_t     sole;
    logic       hazard;
    logic [7:0] wt_wb_pair;

    assign wt_wb_pair = (8'd1 << MT_WT) | (8'd1 << MT_WB);

    always_comb begin
        seen = '0;
        for (int i = 0; i < N; i++) begin
            if (hit_vec[i]) seen[types[i]] = 1'b1;
        end
        sole = MT_UC;
        for (int t = 0; t < 8; t++) begin
            if (seen[t]) sole = 3'(t);
        end
        hazard = seen[0] | seen[2] | seen[3] | seen[7];

        hit = |hit_vec;
        if (!hit)                       rtype = dflt;
        else if (hazard)                rtype = MT_UC;
        else if ($countones(seen) == 1) rtype = sole;
        else if (seen == wt_wb_pair)    rtype = MT_WT;
        else                            rtype = MT_UC;
    end

endmodule

// File: rtl/mtr_resolver.sv
module mtr_resolver
    import mtr_pkg::*;
#(
    parameter int  N_RANGES = 4,
    parameter int  PA_W     = 36,
    localparam int IDX_W    = (N_RANGES > 1) ? $clog2(N_RANGES) : 1,
    localparam int PG_W     = PA_W - PAGE_LSB
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          wr_target,
    input  logic [IDX_W-1:0]    wr_index,
    input  logic [PA_W-1:0]     wr_data,
    input  logic [PA_W-1:0]     lk_addr,
    output logic                lk_hit,
    output logic [2:0]          lk_type,
    output logic [N_RANGES-1:0] lk_hit_vec
);

    logic [N_RANGES-1:0][2:0] etype;
    mtype_t                   dflt_q;
    logic                     unused_low_bits;

    assign unused_low_bits = ^{wr_data[VALID_BIT-1:3], lk_addr[PAGE_LSB-1:0]};

    always_ff @(posedge clk) begin
        if (!rst_n)                                 dflt_q <= MT_UC;
        else if (wr_en && wr_target == TGT_DFLT)    dflt_q <= wr_data[2:0];
    end

    for (genvar i = 0; i < N_RANGES; i++) begin : g_entry
        mtr_range_entry #(
            .PA_W  (PA_W),
            .IDX   (i),
            .IDX_W (IDX_W)
        ) u_entry (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_en),
            .wr_target (wr_target),
            .wr_index  (wr_index),
            .wr_page   (wr_data[PA_W-1:PAGE_LSB]),
            .wr_flag   (wr_data[VALID_BIT]),
            .wr_kind   (wr_data[2:0]),
            .lk_page   (lk_addr[PA_W-1:PAGE_LSB]),
            .match     (lk_hit_vec[i]),
            .mtype     (etype[i])
        );

        // R7: an uncacheable claimant forces an uncacheable hit
        a_r7_uc_dominates: assert property (@(posedge clk) disable iff (!rst_n)
            (lk_hit_vec[i] && etype[i] == MT_UC) |-> (lk_hit && lk_type == MT_UC));

        // R10: reserved codes resolve as uncacheable
        a_r10_reserved_as_uc: assert property (@(posedge clk) disable iff (!rst_n)
            (lk_hit_vec[i] && is_reserved(etype[i])) |-> (lk_type == MT_UC));

        // R6: a lone legal claimant passes its own code through
        a_r6_single_passes_type: assert property (@(posedge clk) disable iff (!rst_n)
            (lk_hit_vec == (N_RANGES'(1) << i) && !is_reserved(etype[i]))
                |-> (lk_type == etype[i]));
    end

    mtr_type_merge #(
        .N (N_RANGES)
    ) u_merge (
        .hit_vec (lk_hit_vec),
        .types   (etype),
        .dflt    (dflt_q),
        .hit     (lk_hit),
        .rtype   (lk_type)
    );

    // R11: no claimant means fallback attribute and no hit
    a_r11_miss_uses_default: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit_vec == '0) |-> (!lk_hit && lk_type == dflt_q));

    // R2: any claimant raises the hit flag
    a_r2_hit_when_any: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit_vec != '0) |-> lk_hit);

endmodule

// File: tb/mtr_resolver_tb.sv
module mtr_resolver_tb;

    localparam int N    = 4;
    localparam int PA_W = 36;

    typedef struct {
        logic [PA_W-1:0] addr;
        logic            hit;
        logic [2:0]      mtype;
        logic [N-1:0]    vec;
        string           tag;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [1:0]      wr_target = '0;
    logic [1:0]      wr_index = '0;
    logic [PA_W-1:0] wr_data = '0;
    logic [PA_W-1:0] lk_addr = '0;
    logic            lk_hit;
    logic [2:0]      lk_type;
    logic [N-1:0]    lk_hit_vec;

    int   checks = 0;
    int   errors = 0;
    logic done = 1'b0;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    mtr_resolver #(.N_RANGES(N), .PA_W(PA_W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_target  (wr_target),
        .wr_index   (wr_index),
        .wr_data    (wr_data),
        .lk_addr    (lk_addr),
        .lk_hit     (lk_hit),
        .lk_type    (lk_type),
        .lk_hit_vec (lk_hit_vec)
    );

    task automatic wr(input logic [1:0] tgt, input logic [1:0] idx, input logic [PA_W-1:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_target = tgt; wr_index = idx; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic look(input logic [PA_W-1:0] a, input logic h, input logic [2:0] t,
                        input logic [N-1:0] v, input string tag);
        exp_t e;
        @(posedge clk); #1;
        lk_addr = a;
        e.addr = a; e.hit = h; e.mtype = t; e.vec = v; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // monitor: compares half a cycle after each address change
    initial begin
        forever begin
            @(negedge clk); #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (lk_hit !== e.hit || lk_type !== e.mtype || lk_hit_vec !== e.vec) begin
                    errors++;
                    $display("FAIL %s addr=%h actual hit=%b type=%0d vec=%b expected hit=%b type=%0d vec=%b",
                             e.tag, e.addr, lk_hit, lk_type, lk_hit_vec, e.hit, e.mtype, e.vec);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        look(36'h0, 1'b0, 3'd0, 4'b0000, "R1 reset state");

        wr(2'd2, 2'd3, 36'h1);                        // R5 fallback = WC, index ignored
        look(36'h1234_5000, 1'b0, 3'd1, 4'b0000, "R11 fallback on miss");

        wr(2'd0, 2'd0, 36'h6);
        wr(2'd1, 2'd0, 36'hF_FC00_0800);
        look(36'h0,         1'b1, 3'd6, 4'b0001, "R12 low end");
        look(36'h3FF_FFFF,  1'b1, 3'd6, 4'b0001, "R12 top end");
        look(36'h400_0000,  1'b0, 3'd1, 4'b0000, "R12 just past");
        look(36'h123,       1'b1, 3'd6, 4'b0001, "R4 low address bits");

        wr(2'd0, 2'd1, 36'h4000_0004);
        wr(2'd1, 2'd1, 36'hF_C000_0000);              // valid clear
        look(36'h4000_0000, 1'b0, 3'd1, 4'b0000, "R3 invalid pair");
        wr(2'd1, 2'd1, 36'hF_C000_0800);
        look(36'h4000_0000, 1'b1, 3'd4, 4'b0010, "R6 single WT");

        wr(2'd0, 2'd2, 36'h4000_0000);
        wr(2'd1, 2'd2, 36'hF_FFFF_F800);
        look(36'h4000_0010, 1'b1, 3'd0, 4'b0110, "R7 UC hole");
        look(36'h4000_1000, 1'b1, 3'd4, 4'b0010, "R7 outside hole");

        wr(2'd0, 2'd3, 36'h4000_0006);
        wr(2'd1, 2'd3, 36'hF_F000_0800);
        look(36'h4800_0000, 1'b1, 3'd4, 4'b1010, "R8 WT plus WB");
        wr(2'd0, 2'd3, 36'h4000_0005);
        look(36'h4800_0000, 1'b1, 3'd0, 4'b1010, "R9 WT plus WP");
        wr(2'd0, 2'd3, 36'h4000_0004);
        look(36'h4800_0000, 1'b1, 3'd4, 4'b1010, "R9 same type twice");

        wr(2'd0, 2'd0, 36'h2);
        look(36'h10_0000, 1'b1, 3'd0, 4'b0001, "R10 reserved code");
        wr(2'd0, 2'd0, 36'hFF6);
        look(36'h10_0000, 1'b1, 3'd6, 4'b0001, "R4 base bits 11:3");

        wr(2'd0, 2'd3, 36'h8_0000_1001);
        wr(2'd1, 2'd3, 36'h8_0000_1800);
        look(36'h8_1234_5000, 1'b1, 3'd1, 4'b1000, "R13 scattered match");
        look(36'h8_1234_4000, 1'b0, 3'd1, 4'b0000, "R13 scattered miss");
        look(36'h0_0000_1000, 1'b1, 3'd6, 4'b0001, "R2 other pair");

        wr(2'd1, 2'd0, 36'hF_FC00_0000);
        look(36'h0, 1'b0, 3'd1, 4'b0000, "R5 rewrite mask invalid");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule